// File: doc/BRIEF.md
# Dual-Path User Permit Concentrator

This block collects fourteen safety permit signals from user systems and combines them into a local permit. The combining is done twice, in two identical paths (A and B) that hold no registered state in common. Downstream logic uses each path's local permit to keep the beam permit loop closed. When a path's permit falls, that loop must be opened.

Any channel can be left out of a path's AND in two ways:

- **Strap disable.** A static strap input removes the channel from one path only. Each channel has one strap per path.
- **Software mask.** A mask written over a one-cycle write strobe removes the channel from both paths.

The software mask may never have more than seven channels set. A write that would go over this limit is refused as a whole, the old mask is kept, and an error flag is raised. Both paths keep their own copy of the mask register and of the error flag.

Top module: `permit_concentrator`

## Requirements
- R1: While `rst` is high at a rising edge, the design goes to this state after that edge: `local_permit_a` = 0, `local_permit_b` = 0, `mask_q` = 0 and `mask_err` = 0.
- R2: A path's local permit is registered. It is 1 one clock after a cycle in which every channel not excluded from that path has `user_permit` bit i = 1. Otherwise it is 0. A path in which every channel is excluded gives 1.
- R3: `strap_dis_a` bit i = 1 excludes channel i from path A only. `strap_dis_b` bit i = 1 excludes channel i from path B only.
- R4: `mask_q` bit i = 1 excludes channel i from both paths. The new mask first affects the permits at the clock after the write edge.
- R5: A write (`mask_wr_en` = 1) whose `mask_wr_data` has seven or fewer bits set is loaded into `mask_q` at that edge, and it clears `mask_err`.
- R6: A write whose data has more than seven bits set leaves `mask_q` unchanged and sets `mask_err`. The flag stays set until an accepted write or a reset. `mask_q` never has more than seven bits set.
- R7: A channel is excluded from a path when its strap or the mask, or both, say so.
- R8: A low channel that is excluded from one path but not from the other drops only the path in which it is still included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_permit | input | 14 | Permit from each user channel, 1 = permit given |
| strap_dis_a | input | 14 | Static per-channel disable for path A |
| strap_dis_b | input | 14 | Static per-channel disable for path B |
| mask_wr_en | input | 1 | Software mask write strobe |
| mask_wr_data | input | 14 | Mask value to write, bit i masks channel i |
| mask_q | output | 14 | Current software mask (union of the two path copies) |
| mask_err | output | 1 | Last mask write was refused for having too many bits set |
| local_permit_a | output | 1 | Registered local permit of path A |
| local_permit_b | output | 1 | Registered local permit of path B |

## Verification
The assertions check the following on every cycle:

- the mask never holds more than seven bits;
- a refused write leaves the mask untouched, and an accepted write loads exactly the data written;
- a low, non-excluded channel always brings its path's permit down one cycle later;
- the two mask copies stay equal.

The bench scenarios cover what needs chosen patterns:

- a strap on one path hiding a low channel while the other path drops;
- straps and the mask overlapping on the same channel;
- the refusal at eight bits, with the flag later cleared by a good write;
- the one-cycle lag between a mask write and its effect on the permits.

// File: rtl/permit_pkg.sv
package permit_pkg;

    localparam int unsigned PERMIT_CHANNELS = 14;
    localparam int unsigned PERMIT_MASK_MAX = 7;
    localparam int unsigned PERMIT_PATHS    = 2;

    typedef enum logic [0:0] {
        PATH_A = 1'b0,
        PATH_B = 1'b1
    } path_id_e;

    typedef struct packed {
        logic                       en;
        logic [PERMIT_CHANNELS-1:0] data;
    } mask_write_t;

endpackage

// File: rtl/permit_mask_reg.sv
module permit_mask_reg #(
    parameter int unsigned N_CH     = permit_pkg::PERMIT_CHANNELS,
    parameter int unsigned MAX_MASK = permit_pkg::PERMIT_MASK_MAX
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [N_CH-1:0] wr_data,
    output logic [N_CH-1:0] mask_q,
    output logic            err_q
);
    localparam int unsigned CW = $clog2(N_CH + 1);

    logic [CW-1:0] set_count;
    logic          over_limit;

    always_comb begin
        set_count = '0;
        for (int i = 0; i < N_CH; i++) begin
            set_count = set_count + CW'(wr_data[i]);
        end
        over_limit = (set_count > CW'(MAX_MASK));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            err_q  <= 1'b0;
        end else if (wr_en) begin
            if (over_limit) begin
                err_q <= 1'b1;
            end else begin
                mask_q <= wr_data;
                err_q  <= 1'b0;
            end
        end
    end

    // R6: the stored mask never exceeds the cap
    a_r6_mask_cap: assert property (@(posedge clk) disable iff (rst)
        $countones(mask_q) <= MAX_MASK);

    // R6: a refused write keeps the old mask and raises the flag
    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $countones(wr_data) > MAX_MASK) |=> ($stable(mask_q) && err_q));

    // R5: an accepted write loads the data and clears the flag
    a_r5_accept_loads: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $countones(wr_data) <= MAX_MASK) |=> (mask_q == $past(wr_data) && !err_q));

endmodule

// File: rtl/permit_and_path.sv
module permit_and_path #(
    parameter int unsigned N_CH = permit_pkg::PERMIT_CHANNELS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] user_permit,
    input  logic [N_CH-1:0] strap_dis,
    input  logic [N_CH-1:0] mask,
    output logic            permit_q
);
    logic [N_CH-1:0] excluded;
    logic [N_CH-1:0] ch_ok;
    logic            all_ok;

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            // strap or mask: either one removes the channel
            assign excluded[i] = strap_dis[i] | mask[i];
            assign ch_ok[i]    = user_permit[i] | excluded[i];
        end
    endgenerate

    assign all_ok = &ch_ok;

    always_ff @(posedge clk) begin
        if (rst) permit_q <= 1'b0;
        else     permit_q <= all_ok;
    end

    // R2: any included channel that is low forces the permit low next cycle
    a_r2_low_drops: assert property (@(posedge clk) disable iff (rst)
        ((~user_permit & ~strap_dis & ~mask) != '0) |=> !permit_q);

endmodule

// File: rtl/permit_concentrator.sv
module permit_concentrator #(
    parameter int unsigned N_CH     = permit_pkg::PERMIT_CHANNELS,
    parameter int unsigned MAX_MASK = permit_pkg::PERMIT_MASK_MAX
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] user_permit,
    input  logic [N_CH-1:0] strap_dis_a,
    input  logic [N_CH-1:0] strap_dis_b,
    input  logic            mask_wr_en,
    input  logic [N_CH-1:0] mask_wr_data,
    output logic [N_CH-1:0] mask_q,
    output logic            mask_err,
    output logic            local_permit_a,
    output logic            local_permit_b
);
    import permit_pkg::*;

    localparam int unsigned NP = PERMIT_PATHS;

    mask_write_t     wr;
    logic [N_CH-1:0] strap [NP];
    logic [N_CH-1:0] mask  [NP];
    logic            err   [NP];
    logic            permit[NP];

    assign wr.en   = mask_wr_en;
    assign wr.data = mask_wr_data;
    assign strap[PATH_A] = strap_dis_a;
    assign strap[PATH_B] = strap_dis_b;

    generate
        for (genvar p = 0; p < NP; p++) begin : g_path
            permit_mask_reg #(.N_CH(N_CH), .MAX_MASK(MAX_MASK)) mask_i (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr.en),
                .wr_data (wr.data),
                .mask_q  (mask[p]),
                .err_q   (err[p])
            );
            permit_and_path #(.N_CH(N_CH)) and_i (
                .clk         (clk),
                .rst         (rst),
                .user_permit (user_permit),
                .strap_dis   (strap[p]),
                .mask        (mask[p]),
                .permit_q    (permit[p])
            );
        end
    endgenerate

    // union of the copies: a disagreement would show as extra masked bits
    assign mask_q         = mask[PATH_A] | mask[PATH_B];
    assign mask_err       = err[PATH_A] | err[PATH_B];
    assign local_permit_a = permit[PATH_A];
    assign local_permit_b = permit[PATH_B];

    // R1: reset state after a reset edge
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!local_permit_a && !local_permit_b && mask_q == '0 && !mask_err));

    // R4: the two independent mask copies agree
    a_r4_copies_agree: assert property (@(posedge clk) disable iff (rst)
        mask[PATH_A] == mask[PATH_B]);

endmodule

// File: tb/permit_concentrator_tb.sv
module permit_concentrator_tb_top;
    localparam int N = 14;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] user_permit, strap_dis_a, strap_dis_b, mask_wr_data, mask_q;
    logic         mask_wr_en, mask_err, local_permit_a, local_permit_b;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #5 clk = ~clk;

    permit_concentrator dut_i (
        .clk(clk), .rst(rst), .user_permit(user_permit),
        .strap_dis_a(strap_dis_a), .strap_dis_b(strap_dis_b),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .mask_q(mask_q), .mask_err(mask_err),
        .local_permit_a(local_permit_a), .local_permit_b(local_permit_b)
    );

    // {user[43:30], strap_a[29:16], strap_b[15:2], exp_a[1], exp_b[0]}, mask = 0
    localparam logic [43:0] VEC [8] = '{
        {14'h3FFF, 14'h0000, 14'h0000, 1'b1, 1'b1},   // R2 all high
        {14'h3FFE, 14'h0000, 14'h0000, 1'b0, 1'b0},   // R2 ch0 low
        {14'h3FFE, 14'h0001, 14'h0000, 1'b1, 1'b0},   // R3 R8 strap A hides ch0
        {14'h1FFF, 14'h0000, 14'h2000, 1'b0, 1'b1},   // R3 R8 strap B hides ch13
        {14'h3FDF, 14'h0020, 14'h0020, 1'b1, 1'b1},   // R3 both straps ch5
        {14'h0000, 14'h3FFF, 14'h3FFF, 1'b1, 1'b1},   // R2 all excluded
        {14'h0000, 14'h0000, 14'h0000, 1'b0, 1'b0},   // R2 all low
        {14'h3DF7, 14'h0208, 14'h0008, 1'b1, 1'b0}    // R8 ch3,ch9 low
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mask(input logic [N-1:0] d);
        mask_wr_en   = 1'b1;
        mask_wr_data = d;
        step();
        mask_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; user_permit = '1; strap_dis_a = '0; strap_dis_b = '0;
        mask_wr_en = 1'b0; mask_wr_data = '0;
        @(negedge clk); step();
        chk("R1 permit a", 32'(local_permit_a), 0);
        chk("R1 permit b", 32'(local_permit_b), 0);
        chk("R1 mask", 32'(mask_q), 0);
        chk("R1 err", 32'(mask_err), 0);
        rst = 1'b0;

        for (int k = 0; k < 8; k++) begin
            user_permit = VEC[k][43:30];
            strap_dis_a = VEC[k][29:16];
            strap_dis_b = VEC[k][15:2];
            step();
            chk($sformatf("R2 R3 R8 vec%0d path a", k), 32'(local_permit_a), 32'(VEC[k][1]));
            chk($sformatf("R2 R3 R8 vec%0d path b", k), 32'(local_permit_b), 32'(VEC[k][0]));
        end

        // R4 R5: seven-bit mask accepted, permit follows one edge later
        user_permit = 14'h3F80; strap_dis_a = '0; strap_dis_b = '0;
        step();
        write_mask(14'h007F);
        chk("R5 mask loaded", 32'(mask_q), 32'h7F);
        chk("R5 err clear", 32'(mask_err), 0);
        chk("R4 permit still old a", 32'(local_permit_a), 0);
        step();
        chk("R4 masked permit a", 32'(local_permit_a), 1);
        chk("R4 masked permit b", 32'(local_permit_b), 1);

        // R6: eight bits refused
        write_mask(14'h00FF);
        chk("R6 mask kept", 32'(mask_q), 32'h7F);
        chk("R6 err set", 32'(mask_err), 1);
        step();
        chk("R6 err held", 32'(mask_err), 1);
        chk("R6 permit unaffected", 32'(local_permit_a), 1);

        // R5: good write clears err, R7 overlap strap+mask
        write_mask(14'h3F80);
        chk("R5 mask upper", 32'(mask_q), 32'h3F80);
        chk("R5 err cleared", 32'(mask_err), 0);
        step();
        chk("R4 ch0-6 low unmasked a", 32'(local_permit_a), 0);
        strap_dis_a = 14'h007F; strap_dis_b = 14'h0080;
        step();
        chk("R7 strap a covers", 32'(local_permit_a), 1);
        chk("R7 b still low", 32'(local_permit_b), 0);

        // R6 full 14-bit write refused
        write_mask(14'h3FFF);
        chk("R6 all bits refused", 32'(mask_q), 32'h3F80);

        // R1 mid-run reset
        rst = 1'b1; step(); rst = 1'b0;
        chk("R1 reset mask", 32'(mask_q), 0);
        chk("R1 reset err", 32'(mask_err), 0);
        chk("R1 reset permit b", 32'(local_permit_b), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule